// File: doc/BRIEF.md
# Memory Operand Effective Address Unit

This unit turns the addressing bytes of one already-decoded instruction into the address of its memory operand. It accepts the addressing-form byte (mode, register/opcode and r/m fields), an optional scale-index-base byte, a displacement of up to 32 bits, the register-extension prefix bits and the address of the following instruction. It reads the general register file through two combinational read ports, one for the base and one for the index. One cycle after an input strobe it presents either a 64-bit effective address or a flag saying the operand is a register, together with that register's number.

In 64-bit mode, the form with no base and a 32-bit displacement (mod=00, r/m=101) is redefined. It becomes relative to the address of the next instruction. This choice looks only at the 3-bit r/m field, so the base-extension prefix bit cannot turn it into register 13. An address-size override keeps the instruction-relative form and narrows the final sum to 32 bits with zero extension. Outside 64-bit mode the prefix bits are ignored and every address is 32 bits wide.

Top module: `modrm_ea_unit`

## Requirements
- R1: On every clock edge where `in_valid` is high, the inputs are captured and `out_valid` is high on the following cycle only. When `in_valid` is low, `out_valid` drops and `out_addr`, `out_is_reg`, `out_reg` and `out_riprel` keep their last values. After reset all outputs are zero.
- R2: A mode field of 11 (addressing byte bits [7:6]) gives `out_is_reg`=1 and `out_reg` = {extension bit B, r/m bits [2:0]}, with `out_addr`=0 and `out_riprel`=0.
- R3: Mode 00 with r/m other than 100 and 101 gives the value of register {B, r/m} as the address.
- R4: Mode 01 adds `disp[7:0]` sign-extended to 64 bits, and the upper displacement bits have no effect. Mode 10 adds all 32 displacement bits, sign-extended.
- R5: r/m=100 in a mode other than 11 selects the scale-index-base byte: scale = bits [7:6] (factor 1, 2, 4 or 8), index = bits [5:3], base = bits [2:0]. The address is base + index×factor + displacement. Register numbers run 0 to 7 in the order accumulator, counter, data, base, stack, frame, source, destination; for example byte 0x81 selects reg1 + reg0×4.
- R6: An index number {X, bits [5:3]} of 0100 means no index. With X=1 the same bits select register 12.
- R7: With the scale-index-base byte, mode 00 and base bits 101 mean no base register plus a 32-bit displacement, whatever B is. In modes 01 and 10, base bits 101 select register {B,101}.
- R8: In 64-bit mode, mode 00 with r/m=101 gives `next_ip` + the sign-extended 32-bit displacement, with `out_riprel`=1, whether B is 0 or 1.
- R9: Outside 64-bit mode, mode 00 with r/m=101 gives the 32-bit displacement zero-extended, with `out_riprel`=0. The extension bits B and X are treated as 0, and every address is truncated to 32 bits and zero-extended.
- R10: In 64-bit mode with `addr_ovr`=1, the computed sum is truncated to 32 bits and zero-extended. The instruction-relative form is still used and still flagged.
- R11: Register 13 with no offset is reached with mode 01, B=1, r/m=101 and a zero 8-bit displacement. This gives that register's value and `out_riprel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe; addressing fields are valid |
| long_mode | input | 1 | 1 = 64-bit mode |
| addr_ovr | input | 1 | Address-size override present |
| rex_b | input | 1 | Extension bit for r/m or base field |
| rex_x | input | 1 | Extension bit for index field |
| modrm | input | 8 | Addressing-form byte |
| sib | input | 8 | Scale-index-base byte |
| disp | input | 32 | Displacement, low byte used for 8-bit form |
| next_ip | input | 64 | Address of the following instruction |
| rf_base_idx | output | 4 | Register-file read address, base port |
| rf_base_data | input | 64 | Register-file read data, base port |
| rf_index_idx | output | 4 | Register-file read address, index port |
| rf_index_data | input | 64 | Register-file read data, index port |
| out_valid | output | 1 | Result valid |
| out_is_reg | output | 1 | Operand is a register, not memory |
| out_reg | output | 4 | Register number for the register form |
| out_addr | output | 64 | Effective address |
| out_riprel | output | 1 | Address was formed from next_ip |

## Verification
A wrong decode of the mode or r/m field shows up at the ports on the cycle after the strobe. It appears either as a wrong `out_is_reg`/`out_riprel` flag or as an address that is off by a whole register value, a displacement or a scaled index. The register values used in the tests differ in their upper 32 bits, so a missing or wrongly applied truncation changes `out_addr[63:32]` at once. Prefix bits that leak into the instruction-relative or no-index cases change the address by a full register value. A result register that updates without a strobe shows as a changed `out_addr` during idle cycles.

// File: rtl/modrm_ea_pkg.sv
package modrm_ea_pkg;

    localparam int REG_W = 4;

    localparam logic [1:0] MOD_NODISP = 2'b00;
    localparam logic [1:0] MOD_D8     = 2'b01;
    localparam logic [1:0] MOD_D32    = 2'b10;
    localparam logic [1:0] MOD_REG    = 2'b11;
    localparam logic [2:0] RM_SIB     = 3'b100;
    localparam logic [2:0] RM_NOBASE  = 3'b101;
    localparam logic [3:0] IDX_NONE   = 4'b0100;

    typedef enum logic [1:0] {
        DSP_NONE = 2'd0,
        DSP_8    = 2'd1,
        DSP_32   = 2'd2
    } disp_kind_e;

    typedef enum logic [1:0] {
        BSRC_NONE = 2'd0,
        BSRC_REG  = 2'd1,
        BSRC_IP   = 2'd2
    } base_src_e;

    typedef struct packed {
        logic             is_reg;
        logic [REG_W-1:0] reg_num;
        base_src_e        bsrc;
        logic [REG_W-1:0] base_num;
        logic             use_index;
        logic [REG_W-1:0] index_num;
        logic [1:0]       scale;
        disp_kind_e       dkind;
    } ea_plan_t;

    typedef struct packed {
        logic        is_reg;
        logic [3:0]  reg_num;
        logic        riprel;
        logic [63:0] addr;
    } ea_result_t;

    function automatic logic [63:0] sext8(input logic [7:0] v);
        return {{56{v[7]}}, v};
    endfunction

    function automatic logic [63:0] sext32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

endpackage

// File: rtl/modrm_ea_decode.sv
module modrm_ea_decode
    import modrm_ea_pkg::*;
(
    input  logic       long_mode,
    input  logic       rex_b,
    input  logic       rex_x,
    input  logic [7:0] modrm,
    input  logic [7:0] sib,
    output ea_plan_t   plan
);
    logic [1:0] mod_f;
    logic [2:0] rm_f;
    logic [1:0] ss_f;
    logic [2:0] ix_f;
    logic [2:0] bs_f;
    logic       eb;
    logic       ex;
    logic       with_sib;

    assign mod_f = modrm[7:6];
    assign rm_f  = modrm[2:0];
    assign ss_f  = sib[7:6];
    assign ix_f  = sib[5:3];
    assign bs_f  = sib[2:0];

    // prefix bits only exist in 64-bit mode
    assign eb = rex_b & long_mode;
    assign ex = rex_x & long_mode;

    assign with_sib = (mod_f != MOD_REG) && (rm_f == RM_SIB);

    always_comb begin
        plan           = '0;
        plan.is_reg    = 1'b0;
        plan.reg_num   = {eb, rm_f};
        plan.bsrc      = BSRC_REG;
        plan.base_num  = {eb, rm_f};
        plan.use_index = 1'b0;
        plan.index_num = {ex, ix_f};
        plan.scale     = 2'b00;
        plan.dkind     = DSP_NONE;

        case (mod_f)
            MOD_D8:  plan.dkind = DSP_8;
            MOD_D32: plan.dkind = DSP_32;
            default: plan.dkind = DSP_NONE;
        endcase

        if (mod_f == MOD_REG) begin
            plan.is_reg = 1'b1;
            plan.bsrc   = BSRC_NONE;
        end else if (with_sib) begin
            plan.base_num  = {eb, bs_f};
            plan.use_index = ({ex, ix_f} != IDX_NONE);
            plan.scale     = ss_f;
            if ((mod_f == MOD_NODISP) && (bs_f == RM_NOBASE)) begin
                plan.bsrc  = BSRC_NONE;
                plan.dkind = DSP_32;
            end
        end else if ((mod_f == MOD_NODISP) && (rm_f == RM_NOBASE)) begin
            // selection uses the 3-bit field only: extension bit has no say
            plan.bsrc  = long_mode ? BSRC_IP : BSRC_NONE;
            plan.dkind = DSP_32;
        end
    end
endmodule

// File: rtl/modrm_ea_combine.sv
module modrm_ea_combine
    import modrm_ea_pkg::*;
#(
    parameter int AW = 64,
    parameter int DW = 32,
    parameter int NW = 32
) (
    input  ea_plan_t          plan,
    input  logic              narrow,
    input  logic [AW-1:0]     base_val,
    input  logic [AW-1:0]     index_val,
    input  logic [AW-1:0]     next_ip,
    input  logic [DW-1:0]     disp,
    output logic [AW-1:0]     addr
);
    localparam int NSCALE = 4;

    logic [AW-1:0] shifted [NSCALE];
    logic [AW-1:0] base_term;
    logic [AW-1:0] index_term;
    logic [AW-1:0] disp_term;
    logic [AW-1:0] wide_sum;

    genvar s;
    generate
        for (s = 0; s < NSCALE; s++) begin : g_scale
            assign shifted[s] = index_val << s;
        end
    endgenerate

    always_comb begin
        case (plan.bsrc)
            BSRC_REG: base_term = base_val;
            BSRC_IP:  base_term = next_ip;
            default:  base_term = '0;
        endcase
    end

    assign index_term = plan.use_index ? shifted[plan.scale] : '0;

    always_comb begin
        case (plan.dkind)
            DSP_8:   disp_term = AW'(sext8(disp[7:0]));
            DSP_32:  disp_term = AW'(sext32(disp[DW-1:0]));
            default: disp_term = '0;
        endcase
    end

    assign wide_sum = base_term + index_term + disp_term;

    generate
        if (NW < AW) begin : g_narrow
            assign addr = narrow ? {{(AW-NW){1'b0}}, wide_sum[NW-1:0]} : wide_sum;
        end else begin : g_full
            assign addr = wide_sum;
        end
    endgenerate
endmodule

// File: rtl/modrm_ea_unit.sv
module modrm_ea_unit
    import modrm_ea_pkg::*;
#(
    parameter int AW = 64,
    parameter int DW = 32,
    parameter int NW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          long_mode,
    input  logic          addr_ovr,
    input  logic          rex_b,
    input  logic          rex_x,
    input  logic [7:0]    modrm,
    input  logic [7:0]    sib,
    input  logic [DW-1:0] disp,
    input  logic [AW-1:0] next_ip,
    output logic [3:0]    rf_base_idx,
    input  logic [AW-1:0] rf_base_data,
    output logic [3:0]    rf_index_idx,
    input  logic [AW-1:0] rf_index_data,
    output logic          out_valid,
    output logic          out_is_reg,
    output logic [3:0]    out_reg,
    output logic [AW-1:0] out_addr,
    output logic          out_riprel
);
    ea_plan_t      plan;
    logic [AW-1:0] sum_addr;
    logic          narrow;

    // 32-bit addressing outside 64-bit mode, or under the size override
    assign narrow = addr_ovr | ~long_mode;

    modrm_ea_decode u_dec (
        .long_mode (long_mode),
        .rex_b     (rex_b),
        .rex_x     (rex_x),
        .modrm     (modrm),
        .sib       (sib),
        .plan      (plan)
    );

    assign rf_base_idx  = plan.base_num;
    assign rf_index_idx = plan.index_num;

    modrm_ea_combine #(.AW(AW), .DW(DW), .NW(NW)) u_sum (
        .plan      (plan),
        .narrow    (narrow),
        .base_val  (rf_base_data),
        .index_val (rf_index_data),
        .next_ip   (next_ip),
        .disp      (disp),
        .addr      (sum_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_is_reg <= 1'b0;
            out_reg    <= '0;
            out_addr   <= '0;
            out_riprel <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_is_reg <= plan.is_reg;
                out_reg    <= plan.is_reg ? plan.reg_num : '0;
                out_addr   <= plan.is_reg ? '0 : sum_addr;
                out_riprel <= ~plan.is_reg & (plan.bsrc == BSRC_IP);
            end
        end
    end
endmodule

// File: rtl/modrm_ea_checker.sv
module modrm_ea_checker #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          long_mode,
    input logic          addr_ovr,
    input logic [7:0]    modrm,
    input logic          out_valid,
    input logic          out_is_reg,
    input logic [AW-1:0] out_addr,
    input logic          out_riprel
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r1_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_addr) && $stable(out_riprel)));

    a_r2_reg_form: assert property (@(posedge clk) disable iff (rst)
        (in_valid && modrm[7:6] == 2'b11) |=> (out_is_reg && out_addr == '0 && !out_riprel));

    a_r8_iprel_flag: assert property (@(posedge clk) disable iff (rst)
        (in_valid && long_mode && modrm[7:6] == 2'b00 && modrm[2:0] == 3'b101)
        |=> (out_riprel && !out_is_reg));

    a_r9_legacy_narrow: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !long_mode) |=> (!out_riprel && out_addr[AW-1:32] == '0));

    a_r10_override_narrow: assert property (@(posedge clk) disable iff (rst)
        (in_valid && addr_ovr) |=> (out_addr[AW-1:32] == '0));
endmodule

bind modrm_ea_unit modrm_ea_checker #(.AW(AW)) u_checker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .long_mode  (long_mode),
    .addr_ovr   (addr_ovr),
    .modrm      (modrm),
    .out_valid  (out_valid),
    .out_is_reg (out_is_reg),
    .out_addr   (out_addr),
    .out_riprel (out_riprel)
);

// File: tb/tb_modrm_ea_unit.sv
module tb_modrm_ea_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        long_mode;
    logic        addr_ovr;
    logic        rex_b;
    logic        rex_x;
    logic [7:0]  modrm;
    logic [7:0]  sib;
    logic [31:0] disp;
    logic [63:0] next_ip;
    logic [3:0]  rf_base_idx;
    logic [63:0] rf_base_data;
    logic [3:0]  rf_index_idx;
    logic [63:0] rf_index_data;
    logic        out_valid;
    logic        out_is_reg;
    logic [3:0]  out_reg;
    logic [63:0] out_addr;
    logic        out_riprel;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] rv(input int i);
        return {8'(8'h10 + i), 24'h0, 32'h4000_0000 + 32'(i) * 32'h100};
    endfunction

    function automatic logic [63:0] lo32(input logic [63:0] v);
        return {32'h0, v[31:0]};
    endfunction

    assign rf_base_data  = rv(int'(rf_base_idx));
    assign rf_index_data = rv(int'(rf_index_idx));

    modrm_ea_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .long_mode(long_mode),
        .addr_ovr(addr_ovr), .rex_b(rex_b), .rex_x(rex_x), .modrm(modrm),
        .sib(sib), .disp(disp), .next_ip(next_ip),
        .rf_base_idx(rf_base_idx), .rf_base_data(rf_base_data),
        .rf_index_idx(rf_index_idx), .rf_index_data(rf_index_data),
        .out_valid(out_valid), .out_is_reg(out_is_reg), .out_reg(out_reg),
        .out_addr(out_addr), .out_riprel(out_riprel)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one request, sample the registered result one cycle later
    task automatic issue(input bit lm, input bit ovr, input bit b, input bit x,
                         input logic [7:0] m, input logic [7:0] s,
                         input logic [31:0] d, input logic [63:0] ip);
        @(negedge clk);
        in_valid = 1; long_mode = lm; addr_ovr = ovr; rex_b = b; rex_x = x;
        modrm = m; sib = s; disp = d; next_ip = ip;
        @(posedge clk);
        #1;
        in_valid = 0;
        chk("R1 valid", 64'(out_valid), 64'd1);
    endtask

    task automatic mem_case(input string req, input logic [63:0] exp_addr, input bit exp_rip);
        chk(req, out_addr, exp_addr);
        chk(req, {62'd0, out_is_reg, out_riprel}, {62'd0, 1'b0, exp_rip});
    endtask

    task automatic t_reset;
        chk("R1 reset valid", 64'(out_valid), 64'd0);
        chk("R1 reset addr", out_addr, 64'd0);
        chk("R1 reset flags", {62'd0, out_is_reg, out_riprel}, 64'd0);
    endtask

    task automatic t_reg_direct;
        issue(1, 0, 1, 0, 8'hC3, 8'h00, 32'h0, 64'h0);
        chk("R2 is_reg", 64'(out_is_reg), 64'd1);
        chk("R2 reg num", 64'(out_reg), 64'd11);
        chk("R2 addr", out_addr, 64'd0);
        chk("R2 riprel", 64'(out_riprel), 64'd0);
        issue(0, 0, 1, 0, 8'hC3, 8'h00, 32'h0, 64'h0);
        chk("R9 legacy reg num", 64'(out_reg), 64'd3);
    endtask

    task automatic t_plain_base;
        issue(1, 0, 0, 0, 8'h13, 8'h00, 32'hFFFF_FFFF, 64'h0);
        mem_case("R3 no disp", rv(3), 0);
        issue(1, 0, 1, 0, 8'h16, 8'h00, 32'h0, 64'h0);
        mem_case("R3 extended base", rv(14), 0);
    endtask

    task automatic t_disp;
        issue(1, 0, 0, 0, 8'h53, 8'h00, 32'h0000_00F0, 64'h0);
        mem_case("R4 disp8 negative", rv(3) - 64'd16, 0);
        issue(1, 0, 0, 0, 8'h53, 8'h00, 32'hDEAD_BE70, 64'h0);
        mem_case("R4 disp8 upper ignored", rv(3) + 64'h70, 0);
        issue(1, 0, 0, 0, 8'h93, 8'h00, 32'h8000_0000, 64'h0);
        mem_case("R4 disp32 sext", rv(3) + 64'hFFFF_FFFF_8000_0000, 0);
    endtask

    task automatic t_sib;
        issue(1, 0, 0, 0, 8'h14, 8'h81, 32'h0, 64'h0);
        mem_case("R5 ecx+eax*4", rv(1) + rv(0) * 4, 0);
        issue(1, 0, 0, 0, 8'h54, 8'h81, 32'h0000_0020, 64'h0);
        mem_case("R5 sib disp8", rv(1) + rv(0) * 4 + 64'h20, 0);
        issue(1, 0, 1, 1, 8'h14, 8'hC1, 32'h0, 64'h0);
        mem_case("R5 extended x8", rv(9) + rv(8) * 8, 0);
        issue(1, 0, 0, 0, 8'h14, 8'h0A, 32'h0, 64'h0);
        mem_case("R5 scale1", rv(2) + rv(1), 0);
    endtask

    task automatic t_no_index;
        issue(1, 0, 0, 0, 8'h14, 8'hA3, 32'h0, 64'h0);
        mem_case("R6 no index", rv(3), 0);
        issue(1, 0, 0, 1, 8'h14, 8'hA3, 32'h0, 64'h0);
        mem_case("R6 r12 index", rv(3) + rv(12) * 4, 0);
    endtask

    task automatic t_sib_nobase;
        issue(1, 0, 0, 0, 8'h14, 8'h45, 32'h0000_0100, 64'h0);
        mem_case("R7 no base", rv(0) * 2 + 64'h100, 0);
        issue(1, 0, 1, 0, 8'h14, 8'h45, 32'h0000_0100, 64'h0);
        mem_case("R7 no base with B", rv(0) * 2 + 64'h100, 0);
        issue(1, 0, 1, 0, 8'h54, 8'h45, 32'h0000_0004, 64'h0);
        mem_case("R7 mod01 base r13", rv(13) + rv(0) * 2 + 64'h4, 0);
    endtask

    task automatic t_iprel;
        logic [63:0] ip = 64'h0000_7FF6_1234_5678;
        issue(1, 0, 0, 0, 8'h05, 8'h00, 32'h0000_0010, ip);
        mem_case("R8 iprel", ip + 64'h10, 1);
        issue(1, 0, 1, 0, 8'h2D, 8'h00, 32'h0000_0010, ip);
        mem_case("R8 iprel with B", ip + 64'h10, 1);
        issue(1, 0, 0, 0, 8'h05, 8'h00, 32'hFFFF_FF00, ip);
        mem_case("R8 iprel negative", ip - 64'h100, 1);
    endtask

    task automatic t_r13;
        issue(1, 0, 1, 0, 8'h45, 8'h00, 32'h0, 64'h0000_1234_0000_0000);
        mem_case("R11 r13 plus zero", rv(13), 0);
    endtask

    task automatic t_legacy;
        issue(0, 0, 0, 0, 8'h05, 8'h00, 32'h8000_1234, 64'h0000_0000_0040_0000);
        mem_case("R9 legacy abs disp", 64'h0000_0000_8000_1234, 0);
        issue(0, 0, 1, 1, 8'h14, 8'hA3, 32'h0, 64'h0);
        mem_case("R9 legacy ext ignored", lo32(rv(3)), 0);
    endtask

    task automatic t_override;
        logic [63:0] ip = 64'h0000_7FF6_FFFF_FFF0;
        issue(1, 1, 0, 0, 8'h05, 8'h00, 32'h0000_0020, ip);
        mem_case("R10 iprel truncated", lo32(ip + 64'h20), 1);
        issue(1, 1, 0, 0, 8'h13, 8'h00, 32'h0, 64'h0);
        mem_case("R10 base truncated", lo32(rv(3)), 0);
    endtask

    task automatic t_hold;
        logic [63:0] keep;
        issue(1, 0, 0, 0, 8'h93, 8'h00, 32'h0000_0555, 64'h0);
        keep = out_addr;
        @(negedge clk);
        modrm = 8'h14; sib = 8'h81; disp = 32'h1;
        repeat (3) @(negedge clk);
        chk("R1 idle valid low", 64'(out_valid), 64'd0);
        chk("R1 idle addr held", out_addr, keep);
        chk("R1 idle addr value", out_addr, rv(3) + 64'h555);
    endtask

    initial begin
        rst = 1; in_valid = 0; long_mode = 0; addr_ovr = 0; rex_b = 0; rex_x = 0;
        modrm = 0; sib = 0; disp = 0; next_ip = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_reg_direct();
        t_plain_base();
        t_disp();
        t_sib();
        t_no_index();
        t_sib_nobase();
        t_iprel();
        t_r13();
        t_legacy();
        t_override();
        t_hold();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule